// File: doc/BRIEF.md
# Serial Channel Interrupt Collector

This block collects the interrupt causes of a group of serial channels (eight by default) and merges them into one host interrupt line. Each channel reports four kinds of cause: the receive buffer reaching its trigger level, the transmit buffer going empty, a special receive condition (break, framing or parity trouble), and a change on any of three modem-status lines (carrier detect, clear-to-send, data-set-ready). Every cause is held in a sticky flag. A per-channel enable register decides which held flags count toward the interrupt.

Software reads one identification byte per channel to learn why that channel interrupted. The read also clears that channel's flags. A group byte shows which channels have an enabled cause pending. A control register holds the global interrupt enable, the end-of-interrupt strobe and a reset-all command. The host line is sticky: once raised it stays up until software strobes end-of-interrupt. If causes are still pending after the strobe, the line comes back up.

Top module: `chan_irq_agg`

## Requirements
- R1: After reset every identification byte, every enable byte, the group byte and the control byte read as zero, and `host_irq` is low.
- R2: A one-cycle pulse on an event input sets a sticky flag in that channel's identification byte, whether or not the matching enable is set: 0x20 for receive trigger, 0x10 for transmit empty, 0x08 for special receive condition.
- R3: Reading a channel's identification byte (address = channel number) returns its flags and clears them at that clock edge. An event that lands in the same cycle as the read stays set.
- R4: A rising or falling transition on a modem input sets a change flag (0x04 carrier detect, 0x02 clear-to-send, 0x01 data-set-ready). The input passes through a two-flop synchronizer, so the flag is visible after the third rising clock edge that follows the input change.
- R5: The enable byte of channel c sits at address NCH+c and keeps only bits 0x10 (transmit empty), 0x04 (special receive), 0x02 (receive trigger) and 0x01 (all three modem-change flags). Other bits read back as zero.
- R6: The group byte at address 2*NCH has bit c set exactly when channel c holds a flag whose enable is set.
- R7: The control byte is at address 2*NCH+1. While its global enable bit 0x08 is clear, `host_irq` stays low. While it is set, `host_irq` rises one clock after any channel has an enabled flag.
- R8: Once raised, `host_irq` stays high even after every cause is cleared, until the control byte is written with the end-of-interrupt bit 0x04.
- R9: `host_irq` is low in the cycle after an end-of-interrupt write. It goes high again one cycle later if an enabled flag is still pending.
- R10: Writing control bit 0x80 clears every flag and every enable byte. While the bit is held, events and enable writes are ignored. Normal operation resumes after a write of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_rx_trig | input | NCH | Per-channel receive-trigger event pulse |
| ev_tx_empty | input | NCH | Per-channel transmit-empty event pulse |
| ev_rx_special | input | NCH | Per-channel special receive condition pulse |
| mdm_cd | input | NCH | Asynchronous carrier-detect lines |
| mdm_cts | input | NCH | Asynchronous clear-to-send lines |
| mdm_dsr | input | NCH | Asynchronous data-set-ready lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (causes clear-on-read) |
| reg_addr | input | AW | Register address, AW = clog2(2*NCH+2) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| host_irq | output | 1 | Sticky host interrupt line |

## Verification
Two faults show up on the very next read. A flag that is latched but wrongly gated reaches the group byte in that read. A flag that was lost or never cleared shows up in the identification byte in that same read. Errors in the host line's sticky state show up within one or two cycles of an end-of-interrupt strobe: the line either fails to drop or fails to come back while a source is pending. The modem path is checked at the exact cycle of its third synchronizing edge, so an extra or missing stage changes what the identification byte returns.

// File: rtl/chan_irq_agg.sv
`timescale 1ns/1ps
module chan_irq_agg #(
  parameter int NCH = 8,
  localparam int AW = $clog2(2*NCH+2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev_rx_trig,
  input  logic [NCH-1:0] ev_tx_empty,
  input  logic [NCH-1:0] ev_rx_special,
  input  logic [NCH-1:0] mdm_cd,
  input  logic [NCH-1:0] mdm_cts,
  input  logic [NCH-1:0] mdm_dsr,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [AW-1:0]  reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic           host_irq
);
  localparam logic [AW-1:0] A_GRP = AW'(2*NCH);
  localparam logic [AW-1:0] A_CTL = AW'(2*NCH+1);
  localparam logic [7:0]    EN_MASK = 8'h17;

  logic [NCH-1:0][5:0] id_q;
  logic [NCH-1:0][7:0] en_q;
  logic [NCH-1:0][2:0] sy1_q, sy2_q, sy3_q;
  logic [NCH-1:0]      active;
  logic                gen_q, rst_all_q, irq_q;

  wire ctl_wr  = reg_wr && (reg_addr == A_CTL);
  wire eoi_wr  = ctl_wr && reg_wdata[2];
  wire hold_rs = rst_all_q || (ctl_wr && reg_wdata[7]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire [2:0] line   = {mdm_cd[c], mdm_cts[c], mdm_dsr[c]};
    wire [2:0] chg    = sy2_q[c] ^ sy3_q[c];
    wire [5:0] set_v  = {ev_rx_trig[c], ev_tx_empty[c], ev_rx_special[c], chg};
    wire       clr    = reg_rd && (reg_addr == AW'(c));
    wire       en_wr  = reg_wr && (reg_addr == AW'(NCH + c));
    wire [5:0] gate_v = {en_q[c][1], en_q[c][4], en_q[c][2], {3{en_q[c][0]}}};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sy1_q[c] <= '0;
        sy2_q[c] <= '0;
        sy3_q[c] <= '0;
      end else begin
        sy1_q[c] <= line;
        sy2_q[c] <= sy1_q[c];
        sy3_q[c] <= sy2_q[c];
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       id_q[c] <= '0;
      else if (hold_rs) id_q[c] <= '0;
      else              id_q[c] <= (clr ? 6'd0 : id_q[c]) | set_v;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       en_q[c] <= '0;
      else if (hold_rs) en_q[c] <= '0;
      else if (en_wr)   en_q[c] <= reg_wdata & EN_MASK;

    assign active[c] = |(id_q[c] & gate_v);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gen_q     <= 1'b0;
      rst_all_q <= 1'b0;
    end else if (ctl_wr) begin
      gen_q     <= reg_wdata[3];
      rst_all_q <= reg_wdata[7];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 irq_q <= 1'b0;
    else if (eoi_wr || !gen_q)  irq_q <= 1'b0;
    else if (|active)           irq_q <= 1'b1;

  assign host_irq = irq_q;

  always_comb begin
    reg_rdata = 8'h00;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == AW'(c))       reg_rdata = {2'b00, id_q[c]};
      if (reg_addr == AW'(NCH + c)) reg_rdata = en_q[c];
    end
    if (reg_addr == A_GRP) reg_rdata = 8'(active);
    if (reg_addr == A_CTL) reg_rdata = {rst_all_q, 3'b000, gen_q, 3'b000};
  end
endmodule

// File: rtl/chan_irq_agg_chk.sv
`timescale 1ns/1ps
module chan_irq_agg_chk #(
  parameter int NCH = 8,
  localparam int AW = $clog2(2*NCH+2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [AW-1:0]    reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             host_irq,
  input logic             gen_q,
  input logic             rst_all_q,
  input logic [6*NCH-1:0] flags
);
  wire ctl_wr = reg_wr && (reg_addr == AW'(2*NCH+1));
  wire eoi_wr = ctl_wr && reg_wdata[2];

  a_r7_gen_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |=> !host_irq);

  a_r8_sticky_line: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && gen_q && !eoi_wr) |=> host_irq);

  a_r9_eoi_drops: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> !host_irq);

  a_r10_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rst_all_q |-> (flags == '0));

  a_r2_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd && !rst_all_q && !(ctl_wr && reg_wdata[7]))
      |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind chan_irq_agg chan_irq_agg_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .host_irq(host_irq),
  .gen_q(gen_q), .rst_all_q(rst_all_q), .flags(id_q)
);

// File: tb/chan_irq_agg_tb_top.sv
`timescale 1ns/1ps
module chan_irq_agg_tb_top;
  localparam int NCH = 8;
  localparam int AW  = $clog2(2*NCH+2);
  localparam int GRP = 2*NCH;
  localparam int CTL = 2*NCH+1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] rxt = '0, txe = '0, spc = '0, cd = '0, cts = '0, dsr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic host_irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chan_irq_agg #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_rx_trig(rxt), .ev_tx_empty(txe),
    .ev_rx_special(spc), .mdm_cd(cd), .mdm_cts(cts), .mdm_dsr(dsr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = AW'(a); #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [NCH-1:0] r, input logic [NCH-1:0] t, input logic [NCH-1:0] s);
    @(negedge clk); rxt = r; txe = t; spc = s;
    @(negedge clk); rxt = '0; txe = '0; spc = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d);     chk("R1 id0", d, 8'h00);
    rd(NCH, d);   chk("R1 en0", d, 8'h00);
    rd(GRP, d);   chk("R1 group", d, 8'h00);
    rd(CTL, d);   chk("R1 ctl", d, 8'h00);
    chk("R1 host_irq", {7'd0, host_irq}, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] d;
    pulse(8'h01, 8'h02, 8'h04);
    rd(0, d);   chk("R2 rx trig latched while disabled", d, 8'h20);
    rd(1, d);   chk("R2 tx empty latched", d, 8'h10);
    rd(GRP, d); chk("R6 nothing enabled", d, 8'h00);
    rd(2, d);   chk("R2 special latched", d, 8'h08);
    rd(0, d);   chk("R3 cleared by read", d, 8'h00);
    @(negedge clk); reg_rd = 1'b1; reg_addr = AW'(4); rxt = 8'h10;
    @(negedge clk); reg_rd = 1'b0; rxt = '0;
    rd(4, d);   chk("R3 same-cycle event kept", d, 8'h20);
  endtask

  task automatic t_modem();
    logic [7:0] d;
    @(negedge clk); cts[3] = 1'b1;
    @(negedge clk);
    rd(3, d);   chk("R4 not yet visible", d, 8'h00);
    rd(3, d);   chk("R4 cts rise at third edge", d, 8'h02);
    @(negedge clk); cd[3] = 1'b1;
    repeat (4) @(negedge clk);
    rd(3, d);   chk("R4 cd rise", d, 8'h04);
    @(negedge clk); cd[3] = 1'b0;
    repeat (4) @(negedge clk);
    rd(3, d);   chk("R4 cd fall", d, 8'h04);
    @(negedge clk); dsr[3] = 1'b1;
    repeat (4) @(negedge clk);
    rd(3, d);   chk("R4 dsr rise", d, 8'h01);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    wr(NCH+7, 8'hFF);
    rd(NCH+7, d); chk("R5 enable mask", d, 8'h17);
    wr(NCH+7, 8'h00);
    wr(NCH+5, 8'h02);
    pulse(8'h20, 8'h40, 8'h00);
    rd(GRP, d); chk("R6 only enabled channel", d, 8'h20);
    wr(NCH+6, 8'h10);
    rd(GRP, d); chk("R6 tx enable adds channel", d, 8'h60);
    @(negedge clk); cts[3] = 1'b0;
    repeat (4) @(negedge clk);
    wr(NCH+3, 8'h01);
    rd(GRP, d); chk("R5 modem enable", d, 8'h68);
    rd(3, d); rd(5, d); rd(6, d);
    rd(GRP, d); chk("R6 cleared", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    pulse(8'h20, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    chk("R7 gated off", {7'd0, host_irq}, 8'h00);
    @(negedge clk); reg_wr = 1'b1; reg_addr = AW'(CTL); reg_wdata = 8'h08;
    @(negedge clk); reg_wr = 1'b0;
    chk("R7 not yet", {7'd0, host_irq}, 8'h00);
    @(negedge clk);
    chk("R7 raised", {7'd0, host_irq}, 8'h01);
    rd(5, d);
    repeat (2) @(negedge clk);
    chk("R8 held after clear", {7'd0, host_irq}, 8'h01);
    wr(CTL, 8'h0C);
    chk("R9 eoi drops", {7'd0, host_irq}, 8'h00);
    @(negedge clk);
    chk("R9 stays low idle", {7'd0, host_irq}, 8'h00);
    pulse(8'h20, 8'h00, 8'h00);
    @(negedge clk);
    chk("R7 raised again", {7'd0, host_irq}, 8'h01);
    wr(CTL, 8'h0C);
    chk("R9 drop with pending", {7'd0, host_irq}, 8'h00);
    @(negedge clk);
    chk("R9 re-assert", {7'd0, host_irq}, 8'h01);
  endtask

  task automatic t_rstall();
    logic [7:0] d;
    wr(CTL, 8'h80);
    rd(NCH+5, d); chk("R10 enable cleared", d, 8'h00);
    rd(5, d);     chk("R10 flags cleared", d, 8'h00);
    chk("R10 line down", {7'd0, host_irq}, 8'h00);
    pulse(8'h01, 8'h00, 8'h00);
    wr(NCH+0, 8'h02);
    rd(0, d);     chk("R10 event ignored", d, 8'h00);
    rd(NCH, d);   chk("R10 enable write ignored", d, 8'h00);
    wr(CTL, 8'h00);
    pulse(8'h01, 8'h00, 8'h00);
    rd(0, d);     chk("R10 resumed", d, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch();
    t_modem();
    t_enable();
    t_irq();
    t_rstall();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule